// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a small synchronous up-counter with a preset path. On each rising clock edge it loads a parallel word, adds one, or keeps its value, depending on three control inputs. The register wraps from its all-ones value back to zero. An active-low clear forces the count and the terminal-count flag to zero at once, without waiting for a clock edge, and overrides every other control.

Counting needs two enables at the same time. The first enable is meant to go to all stages of a chain in common. The second enable also gates the terminal-count output, so a stage passes its carry on only when its own trickle enable is high. This allows several stages to be joined into a wider synchronous counter. In a ripple chain the trickle enables run from one stage to the next. In a lookahead chain the carry of the first stage is also sent to the common enable of every later stage. The default width is four bits, so a stage counts modulo 16.

Top module: `cascade_counter`

## Requirements
- R1: With both enables high and `load_n` high, a stage holding all ones (15 at the default width) holds 0 after the next rising edge.
- R2: While `rst_n` is low, `count` is 0 and `carry_out` is 0. This takes effect without a clock edge and overrides `load_n` and both enables.
- R3: With `rst_n` high and `load_n` low, `count` takes the value of `load_val` at the next rising edge, whatever the enables are.
- R4: With `rst_n` high, `load_n` high and both `en_par` and `en_trk` high, `count` increases by one at the next rising edge.
- R5: With `rst_n` high, `load_n` high and either `en_par` or `en_trk` low, `count` keeps its value across the rising edge.
- R6: `carry_out` is high exactly when `en_trk` is high and `count` is all ones. It follows `en_trk` combinationally, without a clock edge.
- R7: While `load_n` is high, `load_val` has no effect on `count`.
- R8: Three stages in a ripple chain count together as one 12-bit counter and wrap from 4095 to 0. In this chain every `en_par` is tied to a common enable, and each `en_trk` after the first is driven by the previous stage's `carry_out`.
- R9: Three stages in a lookahead chain count together as one 12-bit counter and wrap from 4095 to 0. In this chain the first stage's `carry_out` drives `en_par` of both later stages, and each `en_trk` after the first is driven by the previous stage's `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| load_val | input | WIDTH | Word loaded when `load_n` is low |
| en_par | input | 1 | Count enable shared across a chain |
| en_trk | input | 1 | Count enable that also gates the carry |
| count | output | WIDTH | Counter value |
| carry_out | output | 1 | High when `en_trk` is high and `count` is all ones |

## Verification
The case hardest to reach from the ports is the top stage of a three-stage chain. It moves only once every 256 clocks, and it wraps together with the whole chain only after 4096 clocks. The bench therefore runs both chain forms for more than 4096 consecutive clocks and compares the joined 12-bit value on every cycle, so the 255-to-256 carry and the full wrap are both observed. For a single stage, the bench loads each of the 16 values and then applies all eight load and enable combinations. It also drops the clear in the middle of a cycle, and checks that both outputs go to zero before any edge arrives and stay there while load and count requests are applied.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;

  // Action taken by one stage at the next rising edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2
  } ccnt_act_e;

endpackage

// File: rtl/ccnt_mode_sel.sv
module ccnt_mode_sel
  import ccnt_pkg::*;
(
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output ccnt_act_e act
);

  // Fixed precedence: load, then count, then hold
  always_comb begin
    if (!load_n)
      act = ACT_LOAD;
    else if (en_par && en_trk)
      act = ACT_COUNT;
    else
      act = ACT_HOLD;
  end

endmodule

// File: rtl/ccnt_next.sv
module ccnt_next
  import ccnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  ccnt_act_e          act,
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   load_val,
  output logic [WIDTH-1:0]   nxt,
  output logic               upd
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    unique case (act)
      ACT_LOAD: begin
        nxt = load_val;
        upd = 1'b1;
      end
      ACT_COUNT: begin
        nxt = cur + STEP;   // wraps naturally at 2**WIDTH
        upd = 1'b1;
      end
      default: begin
        nxt = cur;
        upd = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ccnt_term.sv
module ccnt_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_trk,
  output logic             tc
);

  // AND chain over the bits, built bit by bit
  logic [WIDTH:0] all_hi;

  assign all_hi[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    assign all_hi[i+1] = all_hi[i] & cur[i];
  end

  assign tc = all_hi[WIDTH] & en_trk;

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import ccnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_val,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);

  ccnt_act_e        act;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  ccnt_mode_sel u_mode (
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .act    (act)
  );

  ccnt_next #(.WIDTH(WIDTH)) u_next (
    .act      (act),
    .cur      (cnt_q),
    .load_val (load_val),
    .nxt      (cnt_d),
    .upd      (cnt_en)
  );

  // State register: asynchronous clear, explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  ccnt_term #(.WIDTH(WIDTH)) u_term (
    .cur    (cnt_q),
    .en_trk (en_trk),
    .tc     (carry_out)
  );

  assign count = cnt_q;

endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic [WIDTH-1:0] load_val,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // R1: all ones rolls over to zero
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk && (&count)) |=> (count == '0));

  // R2: clear holds both outputs low
  p_clear_r2: assert property (@(posedge clk)
    !rst_n |-> (count == '0 && !carry_out));

  // R3: load takes the parallel word
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (count == $past(load_val)));

  // R4: count steps by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && en_par && en_trk) |=> (count == $past(count) + ONE));

  // R5, R7: hold when an enable is low, whatever load_val is
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_trk)) |=> $stable(count));

  // R6: carry only with trickle enable at all ones
  p_tc_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (en_trk && (&count)));

  p_tc_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_trk && (&count)) |-> carry_out);

endmodule

bind cascade_counter cascade_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_n    (load_n),
  .load_val  (load_val),
  .en_par    (en_par),
  .en_trk    (en_trk),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/cascade_counter_test.sv
module cascade_counter_test;

  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_n;
  logic [3:0] load_val;
  logic       en_par;
  logic       en_trk;
  logic [3:0] count;
  logic       carry_out;

  logic       go;
  logic [3:0] rq0, rq1, rq2, lq0, lq1, lq2;
  logic       rtc0, rtc1, rtc2, ltc0, ltc1, ltc2;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  cascade_counter #(.WIDTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_val(load_val),
    .en_par(en_par), .en_trk(en_trk), .count(count), .carry_out(carry_out)
  );

  // Ripple chain: common en_par, trickle passed stage to stage
  cascade_counter #(.WIDTH(4)) rip0 (.clk(clk), .rst_n(rst_n), .load_n(1'b1), .load_val(4'h0),
    .en_par(go), .en_trk(go), .count(rq0), .carry_out(rtc0));
  cascade_counter #(.WIDTH(4)) rip1 (.clk(clk), .rst_n(rst_n), .load_n(1'b1), .load_val(4'h0),
    .en_par(go), .en_trk(rtc0), .count(rq1), .carry_out(rtc1));
  cascade_counter #(.WIDTH(4)) rip2 (.clk(clk), .rst_n(rst_n), .load_n(1'b1), .load_val(4'h0),
    .en_par(go), .en_trk(rtc1), .count(rq2), .carry_out(rtc2));

  // Lookahead chain: first carry feeds en_par of later stages
  cascade_counter #(.WIDTH(4)) lah0 (.clk(clk), .rst_n(rst_n), .load_n(1'b1), .load_val(4'h0),
    .en_par(go), .en_trk(go), .count(lq0), .carry_out(ltc0));
  cascade_counter #(.WIDTH(4)) lah1 (.clk(clk), .rst_n(rst_n), .load_n(1'b1), .load_val(4'h0),
    .en_par(ltc0), .en_trk(ltc0), .count(lq1), .carry_out(ltc1));
  cascade_counter #(.WIDTH(4)) lah2 (.clk(clk), .rst_n(rst_n), .load_n(1'b1), .load_val(4'h0),
    .en_par(ltc0), .en_trk(ltc1), .count(lq2), .carry_out(ltc2));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    int exp;
    int k;
    rst_n = 1'b1; load_n = 1'b1; load_val = 4'h0;
    en_par = 1'b0; en_trk = 1'b0; go = 1'b0;
    #1 rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R2 reset count", int'(count), 0);
    check("R2 reset carry", int'(carry_out), 0);
    rst_n = 1'b1;

    // Single stage: every start value against every control mix
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        load_n = 1'b0; load_val = 4'(s); en_par = c[0]; en_trk = c[1];
        @(negedge clk);
        check("R3 preload", int'(count), s);
        load_n = c[2]; en_par = c[1]; en_trk = c[0];
        load_val = 4'(s) ^ 4'hA;
        #1;
        check("R6 carry", int'(carry_out), (c[0] && s == 15) ? 1 : 0);
        @(negedge clk);
        if (!c[2]) begin
          exp = s ^ 10;
          check("R3 load", int'(count), exp);
        end else if (c[1] && c[0]) begin
          exp = (s + 1) % 16;
          check(s == 15 ? "R1 wrap" : "R4 step", int'(count), exp);
        end else begin
          check("R5 hold", int'(count), s);
        end
      end
    end

    // R6: carry follows en_trk without an edge
    @(negedge clk);
    load_n = 1'b0; load_val = 4'hF; en_par = 1'b0; en_trk = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    #1 check("R6 carry low", int'(carry_out), 0);
    #1 en_trk = 1'b1;
    #1 check("R6 carry rises", int'(carry_out), 1);
    #1 en_trk = 1'b0;
    #1 check("R6 carry falls", int'(carry_out), 0);

    // R7: changing load_val while load_n high leaves count alone
    @(negedge clk);
    load_n = 1'b0; load_val = 4'h6;
    @(negedge clk);
    load_n = 1'b1; en_par = 1'b1; en_trk = 1'b0;
    for (int v = 0; v < 16; v++) begin
      load_val = 4'(v);
      @(negedge clk);
      check("R7 data ignored", int'(count), 6);
    end

    // R2: clear mid-cycle, then hold clear across edges with requests
    load_n = 1'b0; load_val = 4'hF; en_par = 1'b1; en_trk = 1'b1;
    @(negedge clk);
    load_n = 1'b1;
    #1 check("R6 carry before clear", int'(carry_out), 1);
    #1 rst_n = 1'b0;
    #1 check("R2 async count", int'(count), 0);
    check("R2 async carry", int'(carry_out), 0);
    load_n = 1'b0; load_val = 4'h9;
    @(negedge clk);
    check("R2 overrides load", int'(count), 0);
    load_n = 1'b1;
    @(negedge clk);
    check("R2 overrides count", int'(count), 0);
    check("R2 carry held low", int'(carry_out), 0);
    rst_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;

    // R8, R9: chains run past the full 12-bit wrap
    @(negedge clk);
    check("R8 chain start", int'({rq2, rq1, rq0}), 0);
    check("R9 chain start", int'({lq2, lq1, lq0}), 0);
    go = 1'b1;
    k = 0;
    for (int i = 0; i < 4200; i++) begin
      @(negedge clk);
      k = (k + 1) % 4096;
      check("R8 ripple chain", int'({rq2, rq1, rq0}), k);
      check("R9 lookahead chain", int'({lq2, lq1, lq0}), k);
    end
    go = 1'b0;
    @(negedge clk);
    check("R8 chain hold", int'({rq2, rq1, rq0}), k);
    check("R9 chain hold", int'({lq2, lq1, lq0}), k);

    finish_run();
  end

endmodule